// File: doc/BRIEF.md
# Dual-Channel Shadowed Configuration Register File

This block holds the control settings of a two-channel converter and presents them as flat vectors to the datapath. Software reaches it through a parallel register bus. That bus has a 13-bit address, an 8-bit write port with a write strobe, and a read strobe with registered 8-bit read data. The bus has no back-pressure. Every strobe is accepted in the cycle it is high, so no valid/ready handshake is needed.

Some registers exist once and serve the whole block (global). Others are kept once per channel (local). A channel-select register decides which local copy a bus access reaches. Local registers in a fixed setup window are double-buffered. A write lands in a staging (shadow) copy. A transfer command then moves every staged value of both channels into the active set in one update. This lets a group of settings change on the same clock edge.

Top module: `dual_shadow_regfile`

## Requirements
- R1: A write to an address in 0x008..0x018 changes only the shadow copy, which reads back at once. The active outputs `act_a_o`/`act_b_o` stay unchanged until a transfer.
- R2: Writing a value with bit 0 set to address 0x0FF starts a transfer. At the second rising edge after the write edge, every shadow register of both channels is copied to the active set at once. Register 0x008+i drives bits [8i+7:8i] of `act_a_o`/`act_b_o`.
- R3: A shadow write that falls on the copy edge is not included in that copy. The copy takes the shadow values from before that write.
- R4: The transfer bit clears itself when the copy is done, so a read of 0x0FF afterwards returns 0x00.
- R5: Address 0x005 holds the channel-A select bit (bit 0) and the channel-B select bit (bit 1). Both reset to 1. A write to a local register (0x008..0x018 or 0x100..0x11B) reaches every channel whose select bit is set. Register 0x100+i drives bits [8i+7:8i] of `feat_a_o`/`feat_b_o`.
- R6: A read of a local register follows a fixed priority:
  - the channel-A copy when bit 0 of 0x005 is set, including when both bits are set;
  - otherwise the channel-B copy when bit 1 is set;
  - otherwise 0x00.
- R7: Global registers (0x000..0x002 and 0x019..0x025) have one copy and ignore 0x005. In `glb_o`, 0x000..0x002 occupy slots 0..2 and 0x019..0x025 occupy slots 3..15. Slot k is bits [8k+7:8k].
- R8: On reset, 0x018 loads 0xC0 in both copies and 0x005 loads 0x03. Every other register loads 0x00.
- R9: Reserved bits are not stored and read as 0. In 0x018 only bits 7:6 exist, in 0x005 only bits 1:0, and in 0x0FF only bit 0. Reads of unimplemented addresses return 0x00, and writes to them change nothing.
- R10: Read data is registered. `reg_rdata_o` shows the addressed value in the cycle after the read strobe, and shows 0x00 after any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | 13 | Register address for reads and writes |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Registered read data |
| act_a_o | output | 136 | Active setup registers, channel A |
| act_b_o | output | 136 | Active setup registers, channel B |
| feat_a_o | output | 224 | Local feature registers, channel A |
| feat_b_o | output | 224 | Local feature registers, channel B |
| glb_o | output | 128 | Global registers |

## Verification
A shadow or feature write is visible one cycle later through a read. The read result itself appears in the cycle after its strobe. The bench drives every strobe for one clock, from one falling edge to the next, and samples at that next falling edge, so each read lands in the sampled cycle. Active outputs follow a transfer write after two rising edges. The bench samples them once after the first edge, where they must still hold the old value, and again after the second edge, where the copy must be complete. The same-edge case is checked by placing a shadow write exactly on the copy edge.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  parameter int ADDR_W = 13;
  parameter int DATA_W = 8;
  parameter int N_CH   = 2;

  localparam logic [ADDR_W-1:0] A_CFG_LAST  = 'h002;
  localparam logic [ADDR_W-1:0] A_CHSEL     = 'h005;
  localparam logic [ADDR_W-1:0] A_SHD_FIRST = 'h008;
  localparam logic [ADDR_W-1:0] A_SHD_LAST  = 'h018;
  localparam logic [ADDR_W-1:0] A_REFSEL    = 'h018;
  localparam logic [ADDR_W-1:0] A_GLB_FIRST = 'h019;
  localparam logic [ADDR_W-1:0] A_GLB_LAST  = 'h025;
  localparam logic [ADDR_W-1:0] A_XFER      = 'h0FF;
  localparam logic [ADDR_W-1:0] A_FT_FIRST  = 'h100;
  localparam logic [ADDR_W-1:0] A_FT_LAST   = 'h11B;

  localparam int N_CFG  = int'(A_CFG_LAST) + 1;
  localparam int N_SHD  = int'(A_SHD_LAST - A_SHD_FIRST) + 1;
  localparam int N_GLB  = N_CFG + int'(A_GLB_LAST - A_GLB_FIRST) + 1;
  localparam int N_FEAT = int'(A_FT_LAST - A_FT_FIRST) + 1;
  localparam int N_MAX  = (N_FEAT > N_GLB) ? ((N_FEAT > N_SHD) ? N_FEAT : N_SHD)
                                           : ((N_GLB > N_SHD) ? N_GLB : N_SHD);
  localparam int IDX_W  = $clog2(N_MAX);
  localparam int SEL_W  = N_CH;

  localparam logic [DATA_W-1:0] REF_DEFAULT = DATA_W'(8'hC0);
  localparam logic [DATA_W-1:0] REF_MASK    = DATA_W'(8'hC0);

  typedef enum logic [2:0] {K_NONE, K_GLB, K_SEL, K_SHD, K_FEAT, K_XFER} kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic dec_t addr_decode(logic [ADDR_W-1:0] a);
    dec_t d;
    d.kind = K_NONE;
    d.idx  = '0;
    if (a <= A_CFG_LAST) begin
      d.kind = K_GLB;
      d.idx  = IDX_W'(a);
    end else if (a == A_CHSEL) begin
      d.kind = K_SEL;
    end else if (a >= A_SHD_FIRST && a <= A_SHD_LAST) begin
      d.kind = K_SHD;
      d.idx  = IDX_W'(a - A_SHD_FIRST);
    end else if (a >= A_GLB_FIRST && a <= A_GLB_LAST) begin
      d.kind = K_GLB;
      d.idx  = IDX_W'(a - A_GLB_FIRST) + IDX_W'(N_CFG);
    end else if (a == A_XFER) begin
      d.kind = K_XFER;
    end else if (a >= A_FT_FIRST && a <= A_FT_LAST) begin
      d.kind = K_FEAT;
      d.idx  = IDX_W'(a - A_FT_FIRST);
    end
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] field_mask(dec_t d);
    logic [DATA_W-1:0] m;
    case (d.kind)
      K_NONE: m = '0;
      K_SEL:  m = DATA_W'({SEL_W{1'b1}});
      K_XFER: m = DATA_W'(1'b1);
      K_SHD:  m = (d.idx == IDX_W'(A_REFSEL - A_SHD_FIRST)) ? REF_MASK : '1;
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] shd_default(int i);
    return (i == int'(A_REFSEL - A_SHD_FIRST)) ? REF_DEFAULT : '0;
  endfunction
endpackage

// File: rtl/dsr_chan_bank.sv
module dsr_chan_bank
  import dsr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  dec_t                     dec,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     xfer,
  output logic [DATA_W-1:0]        rd_val,
  output logic [N_SHD*DATA_W-1:0]  act_o,
  output logic [N_FEAT*DATA_W-1:0] feat_o
);
  logic [DATA_W-1:0]       shd_q  [N_SHD];
  logic [DATA_W-1:0]       act_q  [N_SHD];
  logic [DATA_W-1:0]       feat_q [N_FEAT];
  logic [N_SHD*DATA_W-1:0] shd_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SHD; i++) begin
        shd_q[i] <= shd_default(i);
        act_q[i] <= shd_default(i);
      end
      for (int i = 0; i < N_FEAT; i++) feat_q[i] <= '0;
    end else begin
      // transfer copies pre-edge shadow values; a write on this edge is not included
      if (xfer) begin
        for (int i = 0; i < N_SHD; i++) act_q[i] <= shd_q[i];
      end
      if (wr_en && dec.kind == K_SHD) shd_q[dec.idx] <= wdata;
      if (wr_en && dec.kind == K_FEAT) feat_q[dec.idx] <= wdata;
    end
  end

  for (genvar g = 0; g < N_SHD; g++) begin : g_shd_flat
    assign act_o[g*DATA_W +: DATA_W]    = act_q[g];
    assign shd_flat[g*DATA_W +: DATA_W] = shd_q[g];
  end
  for (genvar g = 0; g < N_FEAT; g++) begin : g_feat_flat
    assign feat_o[g*DATA_W +: DATA_W] = feat_q[g];
  end

  always_comb begin
    case (dec.kind)
      K_SHD:   rd_val = shd_q[dec.idx];
      K_FEAT:  rd_val = feat_q[dec.idx];
      default: rd_val = '0;
    endcase
  end

  // R1: active set moves only on a transfer
  p_act_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(act_o));
  // R2/R3: a transfer loads exactly the shadow contents seen before the edge
  p_xfer_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> act_o == $past(shd_flat));
endmodule

// File: rtl/dsr_glb_bank.sv
module dsr_glb_bank
  import dsr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  dec_t                    dec,
  input  logic [DATA_W-1:0]       wdata,
  output logic [SEL_W-1:0]        sel_o,
  output logic                    xfer_o,
  output logic [DATA_W-1:0]       rd_val,
  output logic [N_GLB*DATA_W-1:0] glb_o
);
  logic [DATA_W-1:0] glb_q [N_GLB];
  logic [SEL_W-1:0]  sel_q;
  logic              xfer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_GLB; i++) glb_q[i] <= '0;
      sel_q  <= '1;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= wr_en && dec.kind == K_XFER && wdata[0];
      if (wr_en && dec.kind == K_GLB) glb_q[dec.idx] <= wdata;
      if (wr_en && dec.kind == K_SEL) sel_q <= wdata[SEL_W-1:0];
    end
  end

  for (genvar g = 0; g < N_GLB; g++) begin : g_glb_flat
    assign glb_o[g*DATA_W +: DATA_W] = glb_q[g];
  end

  always_comb begin
    case (dec.kind)
      K_GLB:   rd_val = glb_q[dec.idx];
      K_SEL:   rd_val = DATA_W'(sel_q);
      K_XFER:  rd_val = DATA_W'(xfer_q);
      default: rd_val = '0;
    endcase
  end

  assign sel_o  = sel_q;
  assign xfer_o = xfer_q;

  // R4: transfer bit lasts one cycle unless re-armed by a new command
  p_xfer_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q && !(wr_en && dec.kind == K_XFER) |=> !xfer_q);
endmodule

// File: rtl/dual_shadow_regfile.sv
module dual_shadow_regfile
  import dsr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic                     reg_wr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  input  logic                     reg_rd_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic [N_SHD*DATA_W-1:0]  act_a_o,
  output logic [N_SHD*DATA_W-1:0]  act_b_o,
  output logic [N_FEAT*DATA_W-1:0] feat_a_o,
  output logic [N_FEAT*DATA_W-1:0] feat_b_o,
  output logic [N_GLB*DATA_W-1:0]  glb_o
);
  dec_t                     dec;
  logic [DATA_W-1:0]        wdata_m;
  logic                     is_local;
  logic [SEL_W-1:0]         sel;
  logic                     xfer;
  logic [DATA_W-1:0]        glb_rd;
  logic [DATA_W-1:0]        loc_rd;
  logic [DATA_W-1:0]        ch_rd   [N_CH];
  logic [N_SHD*DATA_W-1:0]  ch_act  [N_CH];
  logic [N_FEAT*DATA_W-1:0] ch_feat [N_CH];
  logic [DATA_W-1:0]        rdata_q;

  assign dec      = addr_decode(reg_addr_i);
  assign wdata_m  = reg_wdata_i & field_mask(dec);
  assign is_local = dec.kind == K_SHD || dec.kind == K_FEAT;

  dsr_glb_bank u_glb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_i),
    .dec    (dec),
    .wdata  (wdata_m),
    .sel_o  (sel),
    .xfer_o (xfer),
    .rd_val (glb_rd),
    .glb_o  (glb_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dsr_chan_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr_i && sel[c]),
      .dec    (dec),
      .wdata  (wdata_m),
      .xfer   (xfer),
      .rd_val (ch_rd[c]),
      .act_o  (ch_act[c]),
      .feat_o (ch_feat[c])
    );
  end

  // lowest-numbered selected channel wins a local read
  always_comb begin
    loc_rd = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (sel[c]) loc_rd = ch_rd[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= is_local ? loc_rd : glb_rd;
    else rdata_q <= '0;
  end

  assign reg_rdata_o = rdata_q;
  assign act_a_o     = ch_act[0];
  assign act_b_o     = ch_act[1];
  assign feat_a_o    = ch_feat[0];
  assign feat_b_o    = ch_feat[1];

  // R5: an unselected channel's local copy is untouched by a write
  p_unsel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && !sel[1] |=> $stable(feat_b_o));
  // R9: writes to holes leave all stored state alone
  p_hole_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && dec.kind == K_NONE |=> $stable(glb_o) && $stable(feat_a_o) && $stable(feat_b_o));
  // R10: no strobe, no data
  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> reg_rdata_o == '0);
  // R7: local writes never alter the global set
  p_glb_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && is_local |=> $stable(glb_o));
endmodule

// File: tb/dual_shadow_regfile_bench.sv
`timescale 1ns/1ps
module dual_shadow_regfile_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [12:0]  addr = '0;
  logic         wr = 1'b0;
  logic [7:0]   wdata = '0;
  logic         rd = 1'b0;
  logic [7:0]   rdata;
  logic [135:0] act_a, act_b;
  logic [223:0] feat_a, feat_b;
  logic [127:0] glb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_shadow_regfile u_dual_shadow_regfile (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rd_i(rd), .reg_rdata_o(rdata),
    .act_a_o(act_a), .act_b_o(act_b), .feat_a_o(feat_a), .feat_b_o(feat_b),
    .glb_o(glb)
  );

  typedef struct packed {
    logic        is_rd;
    logic [12:0] a;
    logic [7:0]  d;
    logic [7:0]  e;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 13'h018, 8'h00, 8'hC0, 4'd8},  // R8 reference default
    '{1'b1, 13'h005, 8'h00, 8'h03, 4'd8},  // R8 select default
    '{1'b1, 13'h000, 8'h00, 8'h00, 4'd8},
    '{1'b0, 13'h108, 8'h5A, 8'h00, 4'd5},  // R5 both channels
    '{1'b1, 13'h108, 8'h00, 8'h5A, 4'd5},
    '{1'b0, 13'h005, 8'h02, 8'h00, 4'd5},
    '{1'b1, 13'h108, 8'h00, 8'h5A, 4'd5},  // R5 B copy got it too
    '{1'b0, 13'h108, 8'h33, 8'h00, 4'd5},
    '{1'b1, 13'h108, 8'h00, 8'h33, 4'd6},  // R6 B only
    '{1'b0, 13'h005, 8'h01, 8'h00, 4'd5},
    '{1'b1, 13'h108, 8'h00, 8'h5A, 4'd5},  // R5 A untouched by B write
    '{1'b0, 13'h005, 8'h03, 8'h00, 4'd6},
    '{1'b1, 13'h108, 8'h00, 8'h5A, 4'd6},  // R6 both set -> A
    '{1'b0, 13'h005, 8'h00, 8'h00, 4'd6},
    '{1'b1, 13'h108, 8'h00, 8'h00, 4'd6},  // R6 none set -> 0
    '{1'b0, 13'h020, 8'h9C, 8'h00, 4'd7},  // R7 global with no select
    '{1'b1, 13'h020, 8'h00, 8'h9C, 4'd7},
    '{1'b0, 13'h005, 8'hFF, 8'h00, 4'd9},
    '{1'b1, 13'h005, 8'h00, 8'h03, 4'd9},  // R9 select reserved bits
    '{1'b0, 13'h018, 8'hFF, 8'h00, 4'd9},
    '{1'b1, 13'h018, 8'h00, 8'hC0, 4'd9},  // R9 reference reserved bits
    '{1'b0, 13'h030, 8'h11, 8'h00, 4'd9},
    '{1'b1, 13'h030, 8'h00, 8'h00, 4'd9},  // R9 hole reads zero
    '{1'b1, 13'h0FF, 8'h00, 8'h00, 4'd4}   // R4 idle transfer bit
  };

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [12:0] a, output logic [7:0] q);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    q = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0]   q;
    logic [127:0] g_snap;
    logic [223:0] fa_snap, fb_snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state on outputs
    chk("R8 act_a", 256'(act_a), 256'({8'hC0, 128'h0}));
    chk("R8 act_b", 256'(act_b), 256'({8'hC0, 128'h0}));
    chk("R8 glb", 256'(glb), 256'h0);
    chk("R8 feat", 256'(feat_a | feat_b), 256'h0);
    chk("R10 rdata idle", 256'(rdata), 256'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) begin
        do_read(VEC[i].a, q);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), 256'(q), 256'(VEC[i].e));
      end else begin
        do_write(VEC[i].a, VEC[i].d);
      end
    end

    // R1: shadow write leaves active set alone
    do_write(13'h008, 8'h12);
    chk("R1 act_a hold", 256'(act_a[7:0]), 256'h0);
    chk("R1 act_b hold", 256'(act_b[7:0]), 256'h0);
    do_read(13'h008, q);
    chk("R1 shadow readback", 256'(q), 256'h12);

    // R2: transfer lands on the second edge
    do_write(13'h0FF, 8'h01);
    chk("R2 not yet copied", 256'(act_a[7:0]), 256'h0);
    @(negedge clk);
    chk("R2 act_a copied", 256'(act_a[7:0]), 256'h12);
    chk("R2 act_b copied", 256'(act_b[7:0]), 256'h12);
    chk("R2 ref kept", 256'(act_a[135:128]), 256'hC0);
    do_read(13'h0FF, q);
    chk("R4 transfer bit cleared", 256'(q), 256'h0);

    // R3: write on the copy edge is excluded from that copy
    do_write(13'h0FF, 8'h01);
    do_write(13'h008, 8'h77);
    chk("R3 copy used old shadow", 256'(act_a[7:0]), 256'h12);
    do_read(13'h008, q);
    chk("R3 shadow took write", 256'(q), 256'h77);
    do_write(13'h0FF, 8'h01);
    @(negedge clk);
    chk("R3 later transfer", 256'(act_b[7:0]), 256'h77);

    // R2: bit 0 clear is no command
    do_write(13'h008, 8'h44);
    do_write(13'h0FF, 8'h02);
    @(negedge clk);
    chk("R2 no command without bit0", 256'(act_a[7:0]), 256'h77);

    // R7: global slot 10 holds 0x020
    chk("R7 glb slot", 256'(glb[80 +: 8]), 256'h9C);
    chk("R5 feat port A", 256'(feat_a[64 +: 8]), 256'h5A);
    chk("R5 feat port B", 256'(feat_b[64 +: 8]), 256'h33);

    // R9: write to hole changes nothing
    g_snap = glb; fa_snap = feat_a; fb_snap = feat_b;
    do_write(13'h1FF, 8'hEE);
    chk("R9 hole glb", 256'(glb), 256'(g_snap));
    chk("R9 hole feat", 256'({feat_a, feat_b} != {fa_snap, fb_snap}), 256'h0);

    // R10: data drops back to zero without a strobe
    do_read(13'h020, q);
    chk("R10 read value", 256'(q), 256'h9C);
    @(negedge clk);
    chk("R10 idle after read", 256'(rdata), 256'h0);

    finish_run();
  end
endmodule